// File: doc/BRIEF.md
# Doorbell-Driven Scatter Queue Remapper

This block lets a remote bus agent reach a large local memory through one small, fixed bus-address window. Local software loads a FIFO with buffer addresses, each aligned to a 4kB page. The entry at the head of the FIFO is the active buffer. Every bus access that falls inside the window is translated to that buffer's page, with the access's low 12 bits kept as the offset within the page.

The remote agent moves on to the next buffer by writing to a separate doorbell address. That write retires the active buffer and makes the next queued one active. The retired buffer address is returned on a completion output so that software can reuse it.

Refused pushes and accesses that find the queue empty are recorded in sticky flags, which only reset clears. An access that finds the queue empty is reported as unmapped.

Top module: `sq_window_remap`

## Requirements
- R1: A push whose address has its low 12 bits all zero is accepted when fewer than DEPTH (16) entries are queued. `q_level` then rises by one and `q_empty` goes low in the following cycle.
- R2: A push whose address has any of its low 12 bits set is refused. `q_level` does not change, and `flag_misalign` goes high and stays high until reset.
- R3: A push made while DEPTH entries are queued is refused. `q_level` stays at DEPTH, and `flag_overflow` goes high and stays high until reset.
- R4: An access whose bit 12 and higher match the window page, made while the queue is not empty, returns `xl_valid`=1 and `xl_mapped`=1 one cycle later. `xl_addr` equals {head page number, access address bits 11:0}, and `xl_write` repeats the access's write bit.
- R5: A doorbell write whose address equals DB_ADDR exactly, made while the queue is not empty, removes the head entry. One cycle later `done_valid`=1 and `done_addr` holds the removed buffer address. Later window accesses use the next entry.
- R6: A doorbell write to any other address has no effect. There is no `done_valid`, the level is unchanged and the active buffer is unchanged.
- R7: A window access or a matching doorbell made while the queue is empty sets `flag_underflow`, which stays high until reset. The access returns `xl_valid`=1, `xl_mapped`=0 and `xl_addr`=0. The doorbell produces no `done_valid`.
- R8: When a window access and a matching doorbell arrive in the same cycle, the access is translated with the buffer that was active before the doorbell.
- R9: An access outside the window page produces no `xl_valid`.
- R10: Buffers become active, and are returned on `done_addr`, in the order in which they were pushed.
- R11: After reset the queue is empty (`q_empty`=1, `q_level`=0), all three flags are 0, and `xl_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Software push strobe |
| push_addr | input | LA_W (40) | Buffer address to queue |
| acc_valid | input | 1 | Bus access strobe |
| acc_write | input | 1 | Bus access is a write |
| acc_addr | input | BA_W (32) | Bus access address |
| db_valid | input | 1 | Bus doorbell write strobe |
| db_addr | input | BA_W (32) | Doorbell write address |
| xl_valid | output | 1 | Translation result valid |
| xl_mapped | output | 1 | Result carries a translated address |
| xl_write | output | 1 | Write bit of the translated access |
| xl_addr | output | LA_W (40) | Translated local address |
| done_valid | output | 1 | A buffer was retired |
| done_addr | output | LA_W (40) | Retired buffer address |
| q_empty | output | 1 | No buffer is queued |
| q_level | output | LVL_W (5) | Number of queued buffers |
| flag_overflow | output | 1 | Sticky: a push was refused because the queue was full |
| flag_underflow | output | 1 | Sticky: an access or doorbell found the queue empty |
| flag_misalign | output | 1 | Sticky: a push had a non-page-aligned address |

## Verification
The hardest situation to bring about from the ports is a doorbell and a window access landing in the same clock edge. Only that case shows whether the translation reads the head entry before or after the pop. The bench drives both strobes in one cycle with at least two buffers queued, then checks that the result uses the old buffer while the completion returns that same buffer. Filling the queue to exactly sixteen entries and pushing once more also takes a long, deliberate sequence. The bench checks that the level stops at sixteen and that the oldest entry still comes out first.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

   // classification of one bus strobe against the window
   typedef enum logic [1:0] {
      HIT_NONE   = 2'd0,
      HIT_WINDOW = 2'd1,
      HIT_BELL   = 2'd2
   } sqr_hit_e;

   // true when the low page bits of an address are all zero
   function automatic logic page_aligned(input logic [63:0] a, input int unsigned pb);
      logic ok;
      ok = 1'b1;
      for (int unsigned k = 0; k < 64; k++) begin
         if (k < pb && a[k]) ok = 1'b0;
      end
      return ok;
   endfunction

endpackage

// File: rtl/sqr_buf_fifo.sv
module sqr_buf_fifo #(
   parameter int PG_W  = 28,
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [PG_W-1:0]  push_page_i,
   input  logic             pop_i,
   output logic [PG_W-1:0]  head_page_o,
   output logic             empty_o,
   output logic             full_o,
   output logic [LVL_W-1:0] level_o
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sqr_buf_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [PTR_W-1:0]            wr_ptr, rd_ptr;
   logic [LVL_W-1:0]            count;
   logic [DEPTH-1:0][PG_W-1:0]  slots;

   // one register per slot, written only when the write pointer selects it
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [PG_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (push_i && wr_ptr == PTR_W'(i))
               q <= push_page_i;
         end
         assign slots[i] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_i) wr_ptr <= wr_ptr + 1'b1;
         if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_i, pop_i})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_page_o = slots[rd_ptr];
   assign empty_o     = (count == '0);
   assign full_o      = (count == LVL_W'(DEPTH));
   assign level_o     = count;

   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LVL_W'(DEPTH));
   assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i);
   assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> !pop_i);

endmodule

// File: rtl/sqr_addr_decode.sv
module sqr_addr_decode
   import sqr_pkg::*;
#(
   parameter int               BA_W          = 32,
   parameter int               PB            = 12,
   parameter logic [BA_W-1:0]  WIN_BASE      = 32'h8000_0000,
   parameter logic [BA_W-1:0]  DB_ADDR       = 32'h8000_1000,
   parameter bit               DB_WHOLE_PAGE = 1'b0
) (
   input  logic            acc_valid_i,
   input  logic [BA_W-1:0] acc_addr_i,
   input  logic            db_valid_i,
   input  logic [BA_W-1:0] db_addr_i,
   output sqr_hit_e        acc_class_o,
   output sqr_hit_e        db_class_o
);

   generate
      if (PB < 1 || PB >= BA_W) begin : g_bad_pb
         $error("sqr_addr_decode: PB must be inside the bus width");
      end
   endgenerate

   logic win_match;
   logic db_match;

   assign win_match = (acc_addr_i[BA_W-1:PB] == WIN_BASE[BA_W-1:PB]);

   // variant: doorbell matched on a whole page or on one exact address
   generate
      if (DB_WHOLE_PAGE) begin : g_db_page
         logic unused_low;
         assign unused_low = ^db_addr_i[PB-1:0];
         assign db_match   = (db_addr_i[BA_W-1:PB] == DB_ADDR[BA_W-1:PB]);
      end else begin : g_db_exact
         assign db_match   = (db_addr_i == DB_ADDR);
      end
   endgenerate

   assign acc_class_o = (acc_valid_i && win_match) ? HIT_WINDOW : HIT_NONE;
   assign db_class_o  = (db_valid_i && db_match)   ? HIT_BELL   : HIT_NONE;

endmodule

// File: rtl/sqr_xlate.sv
module sqr_xlate #(
   parameter int LA_W = 40,
   parameter int PB   = 12,
   localparam int PG_W = LA_W - PB
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit_i,
   input  logic            write_i,
   input  logic [PB-1:0]   offset_i,
   input  logic [PG_W-1:0] head_page_i,
   input  logic            empty_i,
   output logic            xl_valid_o,
   output logic            xl_mapped_o,
   output logic            xl_write_o,
   output logic [LA_W-1:0] xl_addr_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xl_valid_o  <= 1'b0;
         xl_mapped_o <= 1'b0;
         xl_write_o  <= 1'b0;
         xl_addr_o   <= '0;
      end else begin
         xl_valid_o <= hit_i;
         if (hit_i) begin
            xl_write_o  <= write_i;
            xl_mapped_o <= !empty_i;
            xl_addr_o   <= empty_i ? '0 : {head_page_i, offset_i};
         end
      end
   end

   assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i && !empty_i |=> xl_addr_o[PB-1:0] == $past(offset_i));
   assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid_o && !xl_mapped_o |-> xl_addr_o == '0);

endmodule

// File: rtl/sq_window_remap.sv
module sq_window_remap
   import sqr_pkg::*;
#(
   parameter int               BA_W          = 32,
   parameter int               LA_W          = 40,
   parameter int               PB            = 12,
   parameter int               DEPTH         = 16,
   parameter logic [BA_W-1:0]  WIN_BASE      = 32'h8000_0000,
   parameter logic [BA_W-1:0]  DB_ADDR       = 32'h8000_1000,
   parameter bit               DB_WHOLE_PAGE = 1'b0,
   localparam int              LVL_W         = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_valid,
   input  logic [LA_W-1:0]  push_addr,
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [BA_W-1:0]  acc_addr,
   input  logic             db_valid,
   input  logic [BA_W-1:0]  db_addr,
   output logic             xl_valid,
   output logic             xl_mapped,
   output logic             xl_write,
   output logic [LA_W-1:0]  xl_addr,
   output logic             done_valid,
   output logic [LA_W-1:0]  done_addr,
   output logic             q_empty,
   output logic [LVL_W-1:0] q_level,
   output logic             flag_overflow,
   output logic             flag_underflow,
   output logic             flag_misalign
);

   localparam int PG_W = LA_W - PB;

   generate
      if (LA_W <= PB) begin : g_bad_la
         $error("sq_window_remap: LA_W must exceed PB");
      end
      if (WIN_BASE[BA_W-1:PB] == DB_ADDR[BA_W-1:PB]) begin : g_bad_db
         $error("sq_window_remap: doorbell must lie outside the window page");
      end
   endgenerate

   sqr_hit_e        acc_class, db_class;
   logic            win_hit, db_hit;
   logic            full;
   logic            aligned;
   logic            push_ok, pop_ok;
   logic [PG_W-1:0] head_page;

   sqr_addr_decode #(
      .BA_W(BA_W), .PB(PB), .WIN_BASE(WIN_BASE),
      .DB_ADDR(DB_ADDR), .DB_WHOLE_PAGE(DB_WHOLE_PAGE)
   ) i_decode (
      .acc_valid_i (acc_valid),
      .acc_addr_i  (acc_addr),
      .db_valid_i  (db_valid),
      .db_addr_i   (db_addr),
      .acc_class_o (acc_class),
      .db_class_o  (db_class)
   );

   assign win_hit = (acc_class == HIT_WINDOW);
   assign db_hit  = (db_class == HIT_BELL);
   assign aligned = page_aligned(64'(push_addr), PB);
   assign push_ok = push_valid && aligned && !full;
   assign pop_ok  = db_hit && !q_empty;

   sqr_buf_fifo #(.PG_W(PG_W), .DEPTH(DEPTH)) i_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_ok),
      .push_page_i (push_addr[LA_W-1:PB]),
      .pop_i       (pop_ok),
      .head_page_o (head_page),
      .empty_o     (q_empty),
      .full_o      (full),
      .level_o     (q_level)
   );

   // translation samples the head before this cycle's pop lands (R8)
   sqr_xlate #(.LA_W(LA_W), .PB(PB)) i_xlate (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (win_hit),
      .write_i     (acc_write),
      .offset_i    (acc_addr[PB-1:0]),
      .head_page_i (head_page),
      .empty_i     (q_empty),
      .xl_valid_o  (xl_valid),
      .xl_mapped_o (xl_mapped),
      .xl_write_o  (xl_write),
      .xl_addr_o   (xl_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_valid     <= 1'b0;
         done_addr      <= '0;
         flag_overflow  <= 1'b0;
         flag_underflow <= 1'b0;
         flag_misalign  <= 1'b0;
      end else begin
         done_valid <= pop_ok;
         if (pop_ok) done_addr <= {head_page, {PB{1'b0}}};
         if (push_valid && aligned && full) flag_overflow <= 1'b1;
         if (push_valid && !aligned)        flag_misalign <= 1'b1;
         if ((win_hit || db_hit) && q_empty) flag_underflow <= 1'b1;
      end
   end

   assert_done_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      db_hit && !q_empty |=> done_valid && q_level == $past(q_level) - LVL_W'(1)
                                           + LVL_W'($past(push_ok)));
   assert_done_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> done_addr[PB-1:0] == '0);
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_overflow |=> flag_overflow);
   assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_underflow |=> flag_underflow);
   assert_misalign_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flag_misalign |=> flag_misalign);
   assert_misalign_no_growth_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && !aligned && !db_hit |=> q_level == $past(q_level));
   assert_empty_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty |=> !done_valid);

endmodule

// File: tb/test_sq_window_remap.sv
`timescale 1ns/1ps
module test_sq_window_remap;

   localparam int BA_W  = 32;
   localparam int LA_W  = 40;
   localparam int LVL_W = 5;
   localparam logic [BA_W-1:0] DB = 32'h8000_1000;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             push_valid;
   logic [LA_W-1:0]  push_addr;
   logic             acc_valid, acc_write;
   logic [BA_W-1:0]  acc_addr;
   logic             db_valid;
   logic [BA_W-1:0]  db_addr;
   logic             xl_valid, xl_mapped, xl_write;
   logic [LA_W-1:0]  xl_addr;
   logic             done_valid;
   logic [LA_W-1:0]  done_addr;
   logic             q_empty;
   logic [LVL_W-1:0] q_level;
   logic             flag_overflow, flag_underflow, flag_misalign;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   sq_window_remap i_sq_window_remap (
      .clk, .rst_n, .push_valid, .push_addr, .acc_valid, .acc_write, .acc_addr,
      .db_valid, .db_addr, .xl_valid, .xl_mapped, .xl_write, .xl_addr,
      .done_valid, .done_addr, .q_empty, .q_level,
      .flag_overflow, .flag_underflow, .flag_misalign
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      push_valid = 1'b0; push_addr = '0;
      acc_valid  = 1'b0; acc_write = 1'b0; acc_addr = '0;
      db_valid   = 1'b0; db_addr   = '0;
   endtask

   task automatic do_push(input logic [LA_W-1:0] a);
      @(negedge clk);
      push_valid = 1'b1; push_addr = a;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic do_access(input logic [BA_W-1:0] a, input logic wr);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = wr;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic do_bell(input logic [BA_W-1:0] a);
      @(negedge clk);
      db_valid = 1'b1; db_addr = a;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic t_reset();
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 empty", q_empty, 1);
      check("R11 level", q_level, 0);
      check("R11 flags", {flag_overflow, flag_underflow, flag_misalign}, 0);
      check("R11 valids", {xl_valid, done_valid}, 0);
   endtask

   task automatic t_empty_access();
      do_access(32'h8000_0123, 1'b0);
      check("R7 xl_valid", xl_valid, 1);
      check("R7 unmapped", xl_mapped, 0);
      check("R7 addr zero", xl_addr, 0);
      check("R7 underflow", flag_underflow, 1);
      do_bell(DB);
      check("R7 no done on empty", done_valid, 0);
   endtask

   task automatic t_push_and_misalign();
      do_push(40'h12_3456_7000);
      check("R1 level", q_level, 1);
      check("R1 not empty", q_empty, 0);
      do_push(40'h12_0000_0800);
      check("R2 level kept", q_level, 1);
      check("R2 misalign flag", flag_misalign, 1);
   endtask

   task automatic t_translate();
      do_access(32'h8000_0ABC, 1'b1);
      check("R4 valid", xl_valid, 1);
      check("R4 mapped", xl_mapped, 1);
      check("R4 addr", xl_addr, 40'h12_3456_7ABC);
      check("R4 write bit", xl_write, 1);
      do_access(32'h8000_2000, 1'b0);
      check("R9 outside window", xl_valid, 0);
   endtask

   task automatic t_bells();
      do_push(40'h00_0000_1000);
      do_push(40'hFF_FFFF_F000);
      check("R1 level 3", q_level, 3);
      do_bell(32'h8000_1004);
      check("R6 no done", done_valid, 0);
      check("R6 level", q_level, 3);
      do_access(32'h8000_0001, 1'b0);
      check("R6 buffer kept", xl_addr, 40'h12_3456_7001);
      // doorbell and window access in one cycle
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = 32'h8000_0010; acc_write = 1'b0;
      db_valid = 1'b1; db_addr = DB;
      @(negedge clk);
      idle_inputs();
      check("R8 old buffer used", xl_addr, 40'h12_3456_7010);
      check("R5 done valid", done_valid, 1);
      check("R5 done addr", done_addr, 40'h12_3456_7000);
      check("R5 level", q_level, 2);
      do_access(32'h8000_0FFF, 1'b0);
      check("R5 next buffer", xl_addr, 40'h00_0000_1FFF);
      do_bell(DB);
      check("R10 second out", done_addr, 40'h00_0000_1000);
      do_bell(DB);
      check("R10 third out", done_addr, 40'hFF_FFFF_F000);
      check("R5 drained", q_empty, 1);
   endtask

   task automatic t_full();
      for (int i = 0; i < 16; i++) do_push(40'((i + 1) << 12));
      check("R3 level full", q_level, 16);
      check("R3 no flag yet", flag_overflow, 0);
      do_push(40'h00_0002_0000);
      check("R3 level stays", q_level, 16);
      check("R3 overflow flag", flag_overflow, 1);
      do_bell(DB);
      check("R10 oldest first", done_addr, 40'h00_0000_1000);
      do_access(32'h8000_0004, 1'b0);
      check("R10 second active", xl_addr, 40'h00_0000_2004);
   endtask

   initial begin
      t_reset();
      t_empty_access();
      t_push_and_misalign();
      t_translate();
      t_bells();
      t_full();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule